// File: doc/BRIEF.md
# Replayable Packet FIFO

This block buffers a stream of 32-bit words between a producer and a consumer and is built for packet traffic. The producer pushes words over a valid/ready handshake and then pulses a commit strobe at the end of a packet. Only committed words become visible to the consumer. The consumer pops words over its own valid/ready handshake. It holds on to everything it has read until it pulses `rd_mark`, which releases that space back to the producer. If the packet has to be sent again, the consumer pulses `rd_restore` instead. This rewinds it to the last mark, and the same words are delivered once more.

Two flavours exist, and a parameter picks one at elaboration. In the receive flavour (`FIFO_KIND` = 0) the status register reports occupancy. In the transmit flavour (`FIFO_KIND` = 1) it reports vacancy. A small register port serves three purposes: reading an identification word, reading the status word, and writing a key that soft-resets the FIFO.

A packet larger than the whole store leaves the FIFO full for the producer and empty for the consumer at the same time. Neither side can then make progress. A two-state health machine detects this condition. `ST_FLOW` is normal operation. The transition `FLOW->LOCKED` is taken when full and empty hold together. `ST_LOCKED` freezes both handshakes and raises the error interrupt. The transition `LOCKED->FLOW` is taken only on a soft reset.

Top module: `pkt_replay_fifo`

## Requirements
- R1: After `rst_n` is released, `out_valid` is 0, `in_ready` is 1 and `err_irq` is 0. The status word reads 0x8000_0000 in the receive flavour and DEPTH (for example 0x0000_0008) in the transmit flavour.
- R2: Words leave in the order they were pushed. `in_ready` is 0 while DEPTH words are held. A push offered while `in_ready` is 0 stores nothing and changes no count.
- R3: Pushed words stay invisible to the consumer until an `in_commit` pulse. A push in the same cycle as `in_commit` is included in that commit.
- R4: Words that have been read keep occupying space until `rd_mark` is pulsed. The mark releases everything read up to and including a pop in the same cycle. `in_ready` stays 0 after reading from a full FIFO without marking.
- R5: `rd_restore` rewinds the consumer to the last mark, so the words read since that mark are delivered again in their original order.
- R6: If `rd_mark` and `rd_restore` are pulsed in the same cycle, the mark is applied and the restore is dropped.
- R7: Reading byte offset 4 returns the status word. Bits 15:0 hold the count. Bit 31 is the edge flag. Bit 30 is the near flag. Bit 29 is deadlock. All other bits read 0. In the receive flavour, the count is the number of committed unread words, bit 31 means that count is 0, and bit 30 means it is exactly 1. In the transmit flavour, the count is DEPTH minus the words held, bit 31 means that count is 0, and bit 30 means it is exactly 1.
- R8: Reading byte offset 0 returns the `ID_WORD` parameter. Any other offset reads 0.
- R9: Writing 0x0000_000A to byte offset 0 empties the FIFO and clears deadlock in the next cycle. Any other value, or the same value written to another offset, has no effect.
- R10: When the FIFO is full and empty at once, the next cycle enters the locked state. In that state `err_irq` and status bit 29 are 1, and `in_ready` and `out_valid` are 0. Commits, marks and restores are ignored. The state holds until a soft reset.
- R11: A pop requested while `out_valid` is 0 changes no pointer or count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | FIFO accepts a word this cycle |
| in_data | input | DATA_W | Producer word |
| in_commit | input | 1 | Publish all pushed words, including this cycle's |
| out_valid | output | 1 | A committed word is available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_W | Word at the consumer pointer |
| rd_mark | input | 1 | Release the words read so far |
| rd_restore | input | 1 | Rewind the consumer to the last mark |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| err_irq | output | 1 | Deadlock interrupt |

## Verification
The bench runs both flavours side by side on the same stimulus, and several corner cases get particular attention.

- Mark and restore arrive together. A design that lets the restore win replays the old word rather than moving on.
- A push is offered while the FIFO is full. A design that does not gate it overwrites unread data, or makes the count jump.
- A read from a full FIFO is not followed by a mark. A design that computes space from the live read pointer would raise `in_ready` too early.
- A packet of exactly DEPTH words is left uncommitted. It must lock the FIFO, and the later commit must not unlock it. A wrong design would either miss the deadlock or let stale words flow.
- Near-full and near-empty are checked at exactly one word. An off-by-one design flags them one word early or late.
- The soft-reset key is tried with a wrong value and at a wrong offset. A loose decoder would erase data in those cases.

// File: rtl/pfifo_pkg.sv
`timescale 1ns/1ps
package pfifo_pkg;
    // Flavour selector carried by the FIFO_KIND parameter
    localparam int KIND_RX = 0;
    localparam int KIND_TX = 1;

    // Register map (byte offsets)
    localparam int OFS_ID_BYTE   = 0;
    localparam int OFS_STAT_BYTE = 4;

    // Value that must be written at OFS_ID_BYTE to flush the FIFO
    localparam logic [31:0] SOFT_RESET_KEY = 32'h0000_000A;

    // Status word bit positions
    localparam int STAT_EDGE_BIT = 31;
    localparam int STAT_NEAR_BIT = 30;
    localparam int STAT_LOCK_BIT = 29;
    localparam int STAT_CNT_W    = 16;

    typedef enum logic [0:0] {
        ST_FLOW   = 1'b0,
        ST_LOCKED = 1'b1
    } health_e;
endpackage

// File: rtl/pfifo_store.sv
`timescale 1ns/1ps
module pfifo_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int IW     = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // Asynchronous read keeps out_data aligned with out_valid
    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/pfifo_ptrs.sv
`timescale 1ns/1ps
module pfifo_ptrs #(
    parameter int DEPTH = 16,
    parameter int IW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          commit,
    input  logic          mark,
    input  logic          restore,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          full,
    output logic          empty,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_idx,
    output logic [CW-1:0] held,
    output logic [CW-1:0] avail,
    output logic [CW-1:0] rd_pend
);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP      = CW'(DEPTH);

    logic [IW-1:0] mark_idx;
    logic [CW-1:0] wr_pend;
    logic [IW-1:0] wr_idx_n, rd_idx_n, mark_idx_n, rd_adv;
    logic [CW-1:0] held_n, avail_n, rd_pend_n, wr_pend_n;
    logic          do_mark, do_restore, do_commit;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] i);
        return (i == LAST_IDX) ? '0 : i + IW'(1);
    endfunction

    assign full       = (held == CAP);
    assign empty      = (avail == '0);
    assign push_ok    = run && push_req && !full;
    assign pop_ok     = run && pop_req && !empty;
    assign do_mark    = run && mark;
    assign do_restore = run && restore && !mark;   // mark wins
    assign do_commit  = run && commit;

    always_comb begin
        // space held by the producer side, released only by a mark
        held_n = held + CW'(push_ok);
        if (do_mark) begin
            held_n = held_n - rd_pend - CW'(pop_ok);
        end
        // words the consumer may still read
        avail_n = avail - CW'(pop_ok);
        if (do_restore) begin
            avail_n = avail_n + rd_pend + CW'(pop_ok);
        end
        if (do_commit) begin
            avail_n = avail_n + wr_pend + CW'(push_ok);
        end
        rd_pend_n  = (do_mark || do_restore) ? '0 : rd_pend + CW'(pop_ok);
        wr_pend_n  = do_commit ? '0 : wr_pend + CW'(push_ok);
        wr_idx_n   = push_ok ? bump(wr_idx) : wr_idx;
        rd_adv     = pop_ok ? bump(rd_idx) : rd_idx;
        rd_idx_n   = do_restore ? mark_idx : rd_adv;
        mark_idx_n = do_mark ? rd_adv : mark_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            mark_idx <= '0;
            held     <= '0;
            avail    <= '0;
            rd_pend  <= '0;
            wr_pend  <= '0;
        end else if (clear) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            mark_idx <= '0;
            held     <= '0;
            avail    <= '0;
            rd_pend  <= '0;
            wr_pend  <= '0;
        end else begin
            wr_idx   <= wr_idx_n;
            rd_idx   <= rd_idx_n;
            mark_idx <= mark_idx_n;
            held     <= held_n;
            avail    <= avail_n;
            rd_pend  <= rd_pend_n;
            wr_pend  <= wr_pend_n;
        end
    end
endmodule

// File: rtl/pfifo_health_fsm.sv
`timescale 1ns/1ps
module pfifo_health_fsm
    import pfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic full,
    input  logic empty,
    output logic locked
);
    health_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: FLOW->LOCKED on full and empty together, LOCKED->FLOW on clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW:   if (!clear && full && empty) state_d = ST_LOCKED;
            ST_LOCKED: if (clear)                   state_d = ST_FLOW;
            default:                                state_d = ST_FLOW;
        endcase
    end

    // outputs
    always_comb begin
        locked = (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/pfifo_regs.sv
`timescale 1ns/1ps
module pfifo_regs
    import pfifo_pkg::*;
#(
    parameter int          FIFO_KIND = KIND_RX,
    parameter int          DEPTH     = 16,
    parameter int          CW        = 5,
    parameter int          REG_AW    = 4,
    parameter logic [31:0] ID_WORD   = 32'h5046_0101
) (
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic [CW-1:0]     held,
    input  logic [CW-1:0]     avail,
    input  logic              locked,
    output logic [31:0]       reg_rdata,
    output logic              soft_clr
);
    localparam logic [REG_AW-1:0] A_ID   = REG_AW'(OFS_ID_BYTE);
    localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT_BYTE);

    logic [CW-1:0] cnt;
    logic          edge_flag, near_flag;
    logic [31:0]   stat_word;

    generate
        if (FIFO_KIND == KIND_RX) begin : g_rx
            assign cnt = avail;                      // occupancy
        end else begin : g_tx
            assign cnt = CW'(DEPTH) - held;          // vacancy
        end
    endgenerate

    assign edge_flag = (cnt == '0);
    assign near_flag = (cnt == CW'(1));

    always_comb begin
        stat_word                    = '0;
        stat_word[STAT_CNT_W-1:0]    = STAT_CNT_W'(cnt);
        stat_word[STAT_EDGE_BIT]     = edge_flag;
        stat_word[STAT_NEAR_BIT]     = near_flag;
        stat_word[STAT_LOCK_BIT]     = locked;
    end

    always_comb begin
        if (reg_addr == A_ID) begin
            reg_rdata = ID_WORD;
        end else if (reg_addr == A_STAT) begin
            reg_rdata = stat_word;
        end else begin
            reg_rdata = '0;
        end
    end

    assign soft_clr = reg_wr && (reg_addr == A_ID) && (reg_wdata == SOFT_RESET_KEY);
endmodule

// File: rtl/pkt_replay_fifo.sv
`timescale 1ns/1ps
module pkt_replay_fifo
    import pfifo_pkg::*;
#(
    parameter int          DEPTH     = 16,
    parameter int          FIFO_KIND = KIND_RX,
    parameter int          DATA_W    = 32,
    parameter int          REG_AW    = 4,
    parameter logic [31:0] ID_WORD   = 32'h5046_0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_commit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    input  logic              rd_mark,
    input  logic              rd_restore,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              err_irq
);
    // DEPTH must lie in 2..65535 so the count fits the 16-bit field
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          soft_clr, locked, run;
    logic          push_ok, pop_ok, full, empty;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] held_cnt, avail_cnt, rd_pend_cnt;

    assign run = !locked;

    pfifo_ptrs #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) ptrs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (soft_clr),
        .run     (run),
        .push_req(in_valid),
        .pop_req (out_ready),
        .commit  (in_commit),
        .mark    (rd_mark),
        .restore (rd_restore),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .full    (full),
        .empty   (empty),
        .wr_idx  (wr_idx),
        .rd_idx  (rd_idx),
        .held    (held_cnt),
        .avail   (avail_cnt),
        .rd_pend (rd_pend_cnt)
    );

    pfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IW(IW)) store_i (
        .clk    (clk),
        .wr_en  (push_ok),
        .wr_idx (wr_idx),
        .wr_data(in_data),
        .rd_idx (rd_idx),
        .rd_data(out_data)
    );

    pfifo_health_fsm health_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (soft_clr),
        .full  (full),
        .empty (empty),
        .locked(locked)
    );

    pfifo_regs #(
        .FIFO_KIND(FIFO_KIND), .DEPTH(DEPTH), .CW(CW),
        .REG_AW(REG_AW), .ID_WORD(ID_WORD)
    ) regs_i (
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .held     (held_cnt),
        .avail    (avail_cnt),
        .locked   (locked),
        .reg_rdata(reg_rdata),
        .soft_clr (soft_clr)
    );

    assign in_ready  = run && !full;
    assign out_valid = run && !empty;
    assign err_irq   = locked;

    // pop_ok is consumed only by the pointer block; keep it visible for reviews
    logic pop_seen;
    assign pop_seen = pop_ok;
endmodule

// File: rtl/pfifo_checks.sv
`timescale 1ns/1ps
module pfifo_checks #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_clr,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_commit,
    input logic          out_valid,
    input logic          out_ready,
    input logic          rd_mark,
    input logic          rd_restore,
    input logic          err_irq,
    input logic          pop_seen,
    input logic [CW-1:0] held,
    input logic [CW-1:0] avail,
    input logic [CW-1:0] rd_pend
);
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !rd_mark && !soft_clr) |=> (held == $past(held))); // R2

    AST_NO_COMMIT_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_commit && !rd_restore && !soft_clr) |=> (avail <= $past(avail))); // R3

    AST_MARK_BEATS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mark && rd_restore && !err_irq && !soft_clr) |=> (rd_pend == '0)); // R6

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (held == '0 && avail == '0 && !err_irq)); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !soft_clr) |=> err_irq); // R10

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (!in_ready && !out_valid && !pop_seen)); // R10

    AST_EMPTY_POP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !out_valid && !rd_restore && !in_commit && !soft_clr)
        |=> (avail == $past(avail))); // R11
endmodule

bind pkt_replay_fifo pfifo_checks #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_commit (in_commit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .rd_mark   (rd_mark),
    .rd_restore(rd_restore),
    .err_irq   (err_irq),
    .pop_seen  (pop_seen),
    .held      (held_cnt),
    .avail     (avail_cnt),
    .rd_pend   (rd_pend_cnt)
);

// File: tb/pkt_replay_fifo_tb_top.sv
`timescale 1ns/1ps
module pkt_replay_fifo_tb_top;
    localparam int          DEPTH = 8;
    localparam logic [31:0] ID_RX = 32'h5046_0A01;
    localparam logic [31:0] ID_TX = 32'h5046_0B01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_commit = 1'b0, out_ready = 1'b0;
    logic        rd_mark = 1'b0, rd_restore = 1'b0, reg_wr = 1'b0;
    logic [31:0] in_data = '0, reg_wdata = '0;
    logic [3:0]  reg_addr = 4'd4;

    logic        in_ready_rx, out_valid_rx, irq_rx;
    logic        in_ready_tx, out_valid_tx, irq_tx;
    logic [31:0] out_data_rx, out_data_tx, rdata_rx, rdata_tx;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    pkt_replay_fifo #(.DEPTH(DEPTH), .FIFO_KIND(0), .ID_WORD(ID_RX)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_rx),
        .in_data(in_data), .in_commit(in_commit), .out_valid(out_valid_rx),
        .out_ready(out_ready), .out_data(out_data_rx), .rd_mark(rd_mark),
        .rd_restore(rd_restore), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_rx), .err_irq(irq_rx)
    );

    pkt_replay_fifo #(.DEPTH(DEPTH), .FIFO_KIND(1), .ID_WORD(ID_TX)) dut_w (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_tx),
        .in_data(in_data), .in_commit(in_commit), .out_valid(out_valid_tx),
        .out_ready(out_ready), .out_data(out_data_tx), .rd_mark(rd_mark),
        .rd_restore(rd_restore), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_tx), .err_irq(irq_tx)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w, input logic cm);
        in_valid = 1'b1; in_data = w; in_commit = cm;
        tick();
        in_valid = 1'b0; in_commit = 1'b0;
    endtask

    task automatic pop(input string req, input logic [31:0] exp, input logic mk);
        chk(req, "out_valid", {31'b0, out_valid_rx}, 32'd1);
        chk(req, "out_data", out_data_rx, exp);
        out_ready = 1'b1; rd_mark = mk;
        tick();
        out_ready = 1'b0; rd_mark = 1'b0;
    endtask

    task automatic stat(input string req, input logic [31:0] exp_rx, input logic [31:0] exp_tx);
        reg_addr = 4'd4;
        #1;
        chk(req, "rx status", rdata_rx, exp_rx);
        chk(req, "tx status", rdata_tx, exp_tx);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_addr = 4'd4;
    endtask

    task automatic t_reset();
        chk("R1", "out_valid", {31'b0, out_valid_rx}, 32'd0);
        chk("R1", "in_ready", {31'b0, in_ready_rx}, 32'd1);
        chk("R1", "err_irq", {31'b0, irq_rx}, 32'd0);
        stat("R1", 32'h8000_0000, 32'h0000_0008);
        reg_addr = 4'd0; #1;
        chk("R8", "rx id", rdata_rx, ID_RX);
        chk("R8", "tx id", rdata_tx, ID_TX);
        reg_addr = 4'd8; #1;
        chk("R8", "unmapped", rdata_rx, 32'h0);
        reg_addr = 4'd4;
    endtask

    task automatic t_commit();
        push(32'hA0, 1'b0); push(32'hA1, 1'b0); push(32'hA2, 1'b0);
        chk("R3", "hidden before commit", {31'b0, out_valid_rx}, 32'd0);
        stat("R3", 32'h8000_0000, 32'h0000_0005);
        in_commit = 1'b1; tick(); in_commit = 1'b0;
        stat("R3", 32'h0000_0003, 32'h0000_0005);
    endtask

    task automatic t_mark();
        pop("R2", 32'hA0, 1'b0);
        pop("R2", 32'hA1, 1'b0);
        stat("R7", 32'h4000_0001, 32'h0000_0005);   // near-empty, space still held
        pop("R4", 32'hA2, 1'b1);
        stat("R4", 32'h8000_0000, 32'h0000_0008);
    endtask

    task automatic t_restore();
        push(32'hB0, 1'b0); push(32'hB1, 1'b0); push(32'hB2, 1'b1);
        pop("R5", 32'hB0, 1'b0);
        pop("R5", 32'hB1, 1'b0);
        rd_restore = 1'b1; tick(); rd_restore = 1'b0;
        stat("R5", 32'h0000_0003, 32'h0000_0005);
        pop("R5", 32'hB0, 1'b0);
        pop("R5", 32'hB1, 1'b0);
        pop("R5", 32'hB2, 1'b1);
        stat("R5", 32'h8000_0000, 32'h0000_0008);
    endtask

    task automatic t_priority();
        push(32'hC0, 1'b0); push(32'hC1, 1'b1);
        pop("R6", 32'hC0, 1'b0);
        rd_mark = 1'b1; rd_restore = 1'b1; tick(); rd_mark = 1'b0; rd_restore = 1'b0;
        stat("R6", 32'h4000_0001, 32'h0000_0007);
        pop("R6", 32'hC1, 1'b1);
        stat("R6", 32'h8000_0000, 32'h0000_0008);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH - 1; i++) push(32'hD0 + 32'(i), 1'b0);
        stat("R7", 32'h8000_0000, 32'h4000_0001);   // near-full at one free word
        push(32'hD7, 1'b1);
        stat("R7", 32'h0000_0008, 32'h8000_0000);
        chk("R2", "in_ready when full", {31'b0, in_ready_rx}, 32'd0);
        in_valid = 1'b1; in_data = 32'hDEAD; tick(); in_valid = 1'b0;
        stat("R2", 32'h0000_0008, 32'h8000_0000);
        pop("R2", 32'hD0, 1'b0);
        chk("R4", "in_ready after unmarked read", {31'b0, in_ready_rx}, 32'd0);
        for (int i = 1; i < DEPTH; i++) pop("R2", 32'hD0 + 32'(i), (i == DEPTH - 1));
        chk("R2", "drained", {31'b0, out_valid_rx}, 32'd0);
        chk("R4", "space back", {31'b0, in_ready_rx}, 32'd1);
        out_ready = 1'b1; tick(); out_ready = 1'b0;
        stat("R11", 32'h8000_0000, 32'h0000_0008);
        push(32'hE0, 1'b1);
        pop("R11", 32'hE0, 1'b1);
    endtask

    task automatic t_soft();
        push(32'hF0, 1'b0); push(32'hF1, 1'b1);
        reg_write(4'd0, 32'h0000_0005);
        stat("R9", 32'h0000_0002, 32'h0000_0006);
        reg_write(4'd4, 32'h0000_000A);
        stat("R9", 32'h0000_0002, 32'h0000_0006);
        reg_write(4'd0, 32'h0000_000A);
        stat("R9", 32'h8000_0000, 32'h0000_0008);
        chk("R9", "out_valid after flush", {31'b0, out_valid_rx}, 32'd0);
    endtask

    task automatic t_deadlock();
        for (int i = 0; i < DEPTH; i++) push(32'h90 + 32'(i), 1'b0);
        tick();
        chk("R10", "rx irq", {31'b0, irq_rx}, 32'd1);
        chk("R10", "tx irq", {31'b0, irq_tx}, 32'd1);
        chk("R10", "in_ready", {31'b0, in_ready_rx}, 32'd0);
        stat("R10", 32'hA000_0000, 32'hA000_0000);
        in_commit = 1'b1; tick(); in_commit = 1'b0;
        chk("R10", "commit ignored", {31'b0, out_valid_rx}, 32'd0);
        chk("R10", "irq held", {31'b0, irq_rx}, 32'd1);
        stat("R10", 32'hA000_0000, 32'hA000_0000);
        reg_write(4'd0, 32'h0000_000A);
        chk("R10", "irq cleared", {31'b0, irq_rx}, 32'd0);
        stat("R10", 32'h8000_0000, 32'h0000_0008);
        push(32'h77, 1'b1);
        pop("R10", 32'h77, 1'b1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_commit();
        t_mark();
        t_restore();
        t_priority();
        t_full();
        t_soft();
        t_deadlock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule